// File: doc/BRIEF.md
# Seven-slot serial display link deserializer

This block turns a serial display link back into parallel pixel words. The link has one reference lane that carries the link clock as a level pattern, and four data lanes. Each data lane carries seven bits in every link clock period. Every lane is sampled once per bit clock (`clk_i`), which runs at seven times the pixel rate. In the chip this clock comes from a clock-recovery stage outside the block; in simulation the bench supplies it. The block finds the word boundary from the reference lane and assembles a 28-bit word. It presents that word as 24 colour bits plus horizontal sync, vertical sync, data enable and one spare control bit.

A lock tracker watches the position of the reference pattern. Words reach the outputs only after the pattern has shown up at a steady seven-slot spacing. A pixel clock output is produced while the block is locked. Its falling edge lands in the middle of each word, so the outputs are steady when a downstream stage samples them on that edge. If the link clock pattern disappears, lock drops, the pixel clock halts low and the last word stays on the outputs. An active-low power-down input, `pwr_ni`, can be asserted at any time. It stops deserialization and clears the block. After release the block searches for alignment again from the beginning.

Top module: `pix_link_deser`

## Requirements
- R1: During and directly after reset, `lock_o`, `pix_clk_o` and every word output (`rgb_o`, `hsync_o`, `vsync_o`, `de_o`, `ctl_o`) are 0.
- R2: A word boundary is recognised only when the last eight reference-lane samples, oldest first, are 0,1,1,1,1,0,0,0. The first high sample is slot 0 of the word. A reference pattern with three or five high slots is never recognised, and lock stays low.
- R3: In each lane, the bit received in slot 0 goes to the top position of that lane's 7-bit group and the bit in slot 6 goes to its bottom position. Lane n fills word bits 7n+6 down to 7n. Word bits 23:0 drive `rgb_o`, and bits 24, 25, 26 and 27 drive `hsync_o`, `vsync_o`, `de_o` and `ctl_o`.
- R4: `lock_o` rises on the bit clock edge at which the fourth consecutive boundary is recognised, each boundary being exactly seven bit clocks after the previous one.
- R5: Word outputs change only when a boundary is recognised while `lock_o` is already high. The word is loaded on the first bit clock edge after its slot 6 was sampled, so the first word loaded after acquisition is the fifth.
- R6: While locked, `pix_clk_o` goes high on the word-load edge, stays high for four bit clocks and is low for three. Word outputs never change at its falling edge. While unlocked it is low.
- R7: A single word period without a recognised boundary keeps `lock_o` high, and the next aligned word is loaded normally.
- R8: Two consecutive word periods without a recognised boundary clear `lock_o`. The pixel clock then stays low and the word outputs keep their last value.
- R9: While `pwr_ni` is low, at every bit clock edge the block clears lock, pixel clock, word outputs and sampled lane history, whatever the lanes carry.
- R10: After `pwr_ni` returns high, lock needs four fresh aligned boundaries again and the outputs stay 0 until the fifth word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, seven cycles per pixel period |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_ni | input | 1 | Active-low power-down |
| ck_lane_i | input | 1 | Sampled reference (link clock) lane |
| data_lane_i | input | 4 | Sampled data lanes, one bit per lane |
| pix_clk_o | output | 1 | Pixel clock; outputs are steady at its falling edge |
| lock_o | output | 1 | Word alignment lock |
| rgb_o | output | 24 | Colour bits of the current word |
| hsync_o | output | 1 | Horizontal sync bit |
| vsync_o | output | 1 | Vertical sync bit |
| de_o | output | 1 | Data enable bit |
| ctl_o | output | 1 | Spare control bit |

## Verification
A framing offset or reversed slot order inside the block appears at the outputs as rotated or mirrored lane groups in the very first loaded word. That is one bit clock after the fifth aligned word ends, and directed single-bit words make the position unambiguous. A wrong lock or miss count moves the rise or fall of `lock_o` by a whole word period, and with it the word that first appears. The bench compares the outputs against its own model once per word. A slot counter that drifts from the boundary shows up as a pixel clock that is high or low in the wrong bit slots. It also shows up as a word that changes between load edges, which the bench samples at every bit clock.

// File: rtl/link_deser_pkg.sv
package link_deser_pkg;
  localparam int unsigned LINK_LANES    = 4;
  localparam int unsigned LINK_SLOTS    = 7;
  localparam int unsigned LINK_HI_SLOTS = 4;
  localparam int unsigned LINK_LOCK_N   = 4;
  localparam int unsigned LINK_MISS_N   = 2;
endpackage

// File: rtl/link_deser_lane.sv
module link_deser_lane #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             d_i,
  output logic [SLOTS-1:0] q_o
);
  // oldest sample ends up in the top bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= {q_o[SLOTS-2:0], d_i};
  end
endmodule

// File: rtl/link_deser_frame.sv
module link_deser_frame #(
  parameter int unsigned SLOTS    = 7,
  parameter int unsigned HI_SLOTS = 4,
  parameter int unsigned LOCK_N   = 4,
  parameter int unsigned MISS_N   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic ck_lane_i,
  output logic load_o,
  output logic lock_o,
  output logic pclk_o
);
  localparam int unsigned PW      = $clog2(SLOTS);
  localparam int unsigned GW      = $clog2(LOCK_N + 1);
  localparam int unsigned MW      = $clog2(MISS_N + 1);
  localparam int unsigned PCLK_HI = (SLOTS + 1) / 2;
  localparam logic [SLOTS:0] PAT  = (SLOTS+1)'(((1 << HI_SLOTS) - 1) << (SLOTS - HI_SLOTS));

  logic [SLOTS:0] hist_q;
  logic [PW-1:0]  cnt_q, cnt_n;
  logic [GW-1:0]  good_q, good_n;
  logic [MW-1:0]  miss_q, miss_n;
  logic           lock_q, lock_n, pclk_q;
  logic           match, last;

  assign match = (hist_q == PAT);
  assign last  = (cnt_q == PW'(SLOTS - 1));

  always_comb begin
    cnt_n  = last ? '0 : cnt_q + PW'(1);
    good_n = good_q;
    miss_n = miss_q;
    lock_n = lock_q;
    if (match) begin
      cnt_n = '0;
      if (last) begin
        miss_n = '0;
        if (good_q != GW'(LOCK_N)) good_n = good_q + GW'(1);
      end else begin
        good_n = GW'(1);  // boundary moved: restart count
      end
    end else if (last) begin
      good_n = '0;
      if (miss_q != MW'(MISS_N)) miss_n = miss_q + MW'(1);
    end
    if (good_n == GW'(LOCK_N)) lock_n = 1'b1;
    if (miss_n == MW'(MISS_N)) lock_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      cnt_q  <= '0;
      good_q <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
      pclk_q <= 1'b0;
    end else if (clr_i) begin
      hist_q <= '0;
      cnt_q  <= '0;
      good_q <= '0;
      miss_q <= '0;
      lock_q <= 1'b0;
      pclk_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[SLOTS-1:0], ck_lane_i};
      cnt_q  <= cnt_n;
      good_q <= good_n;
      miss_q <= miss_n;
      lock_q <= lock_n;
      pclk_q <= lock_n && (cnt_n < PW'(PCLK_HI));
    end
  end

  assign load_o = match && last && lock_q;
  assign lock_o = lock_q;
  assign pclk_o = pclk_q;
endmodule

// File: rtl/link_deser_word.sv
module link_deser_word #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] lanes_i,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_o <= '0;
    else if (clr_i)  word_o <= '0;
    else if (load_i) word_o <= lanes_i;
  end
endmodule

// File: rtl/pix_link_deser.sv
module pix_link_deser import link_deser_pkg::*; #(
  parameter int unsigned LANES    = LINK_LANES,
  parameter int unsigned SLOTS    = LINK_SLOTS,
  parameter int unsigned HI_SLOTS = LINK_HI_SLOTS,
  parameter int unsigned LOCK_N   = LINK_LOCK_N,
  parameter int unsigned MISS_N   = LINK_MISS_N
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     pwr_ni,
  input  logic                     ck_lane_i,
  input  logic [LANES-1:0]         data_lane_i,
  output logic                     pix_clk_o,
  output logic                     lock_o,
  output logic [LANES*SLOTS-5:0]   rgb_o,
  output logic                     hsync_o,
  output logic                     vsync_o,
  output logic                     de_o,
  output logic                     ctl_o
);
  localparam int unsigned WORD_W = LANES * SLOTS;
  localparam int unsigned RGB_W  = WORD_W - 4;

  logic              clr, load;
  logic [WORD_W-1:0] lane_bus, word_q;

  assign clr = !pwr_ni;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    link_deser_lane #(.SLOTS(SLOTS)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .d_i    (data_lane_i[g]),
      .q_o    (lane_bus[g*SLOTS +: SLOTS])
    );
  end

  link_deser_frame #(
    .SLOTS(SLOTS), .HI_SLOTS(HI_SLOTS), .LOCK_N(LOCK_N), .MISS_N(MISS_N)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .ck_lane_i (ck_lane_i),
    .load_o    (load),
    .lock_o    (lock_o),
    .pclk_o    (pix_clk_o)
  );

  link_deser_word #(.WORD_W(WORD_W)) u_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .load_i  (load),
    .lanes_i (lane_bus),
    .word_o  (word_q)
  );

  assign rgb_o   = word_q[RGB_W-1:0];
  assign hsync_o = word_q[RGB_W];
  assign vsync_o = word_q[RGB_W+1];
  assign de_o    = word_q[RGB_W+2];
  assign ctl_o   = word_q[RGB_W+3];
endmodule

// File: rtl/link_deser_chk.sv
module link_deser_chk #(
  parameter int unsigned WORD_W = 28
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pwr_ni,
  input logic              lock_i,
  input logic              pclk_i,
  input logic [WORD_W-1:0] word_i
);
  a_r6_pclk_low_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |-> !pclk_i);

  a_r6_word_steady_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pclk_i) && $past(pwr_ni)) |-> $stable(word_i));

  a_r5_update_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(word_i) |-> ($past(lock_i) || !$past(pwr_ni)));

  a_r8_hold_when_unlocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_i && pwr_ni) |=> $stable(word_i));

  a_r9_powerdown_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ni |=> (word_i == '0 && !lock_i && !pclk_i));
endmodule

bind pix_link_deser link_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pwr_ni (pwr_ni),
  .lock_i (lock_o),
  .pclk_i (pix_clk_o),
  .word_i (word_q)
);

// File: tb/sim_pix_link_deser.sv
module sim_pix_link_deser;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwr_ni = 1'b1;
  logic        ck_lane = 1'b0;
  logic [3:0]  dl = '0;
  logic        pix_clk_o, lock_o, hsync_o, vsync_o, de_o, ctl_o;
  logic [23:0] rgb_o;

  always #4ns clk = ~clk;

  pix_link_deser u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_ni(pwr_ni), .ck_lane_i(ck_lane),
    .data_lane_i(dl), .pix_clk_o(pix_clk_o), .lock_o(lock_o), .rgb_o(rgb_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .ctl_o(ctl_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R1";

  // model state
  bit          prev_valid, prev_live, lock_m;
  logic [27:0] prev_w, exp_w;
  int          good_m, miss_m;

  task automatic chk(input bit ok, input string req, input logic [27:0] act, input logic [27:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] out_word();
    return {ctl_o, de_o, vsync_o, hsync_o, rgb_o};
  endfunction

  // R3: slot k of lane l carries word bit 7l+6-k
  function automatic logic lane_bit(input logic [27:0] w, input int l, input int k);
    return w[7*l+6-k];
  endfunction

  function automatic logic [27:0] rnd28();
    return 28'($urandom());
  endfunction

  task automatic reset_model();
    prev_valid = 0; prev_live = 0; lock_m = 0;
    prev_w = '0; exp_w = '0; good_m = 0; miss_m = 0;
  endtask

  task automatic eval_prev();
    if (prev_valid) begin
      if (prev_live) begin
        if (lock_m) exp_w = prev_w;
        if (good_m < 4) good_m++;
        miss_m = 0;
        if (good_m >= 4) lock_m = 1;
      end else begin
        good_m = 0;
        if (miss_m < 2) miss_m++;
        if (miss_m >= 2) lock_m = 0;
      end
    end
    chk(lock_o == lock_m, {tag, " R4 lock"}, 28'(lock_o), 28'(lock_m));
    chk(pix_clk_o == lock_m, {tag, " R6 pclk high at load"}, 28'(pix_clk_o), 28'(lock_m));
  endtask

  // hi = number of high slots on the reference lane; 4 is a valid word, 0 is a dead period
  task automatic send_word(input logic [27:0] w, input int hi);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k == 1) eval_prev();
      else if (!lock_m) chk(pix_clk_o == 1'b0, {tag, " R8 pclk halted"}, 28'(pix_clk_o), 28'd0);
      if (k == 5 && lock_m) chk(pix_clk_o == 1'b0, {tag, " R6 pclk low slot"}, 28'(pix_clk_o), 28'd0);
      chk(out_word() == exp_w, {tag, " R5 word"}, out_word(), exp_w);
      ck_lane = (k < hi);
      for (int l = 0; l < 4; l++) dl[l] = lane_bit(w, l, k);
    end
    prev_valid = 1;
    prev_live  = (hi == 4);
    prev_w     = w;
  endtask

  initial begin
    #160us;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20461));
    reset_model();
    repeat (3) @(negedge clk);
    chk(out_word() == '0 && !lock_o && !pix_clk_o, "R1 in reset", {out_word()}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_word() == '0 && !lock_o && !pix_clk_o, "R1 after reset", out_word(), '0);

    // wrong duty on the reference lane never aligns
    tag = "R2";
    repeat (3) send_word(rnd28(), 3);
    repeat (3) send_word(rnd28(), 5);
    @(negedge clk);
    chk(lock_o == 1'b0, "R2 bad pattern no lock", 28'(lock_o), 28'd0);
    ck_lane = 1'b0;

    tag = "R4";
    repeat (5) send_word(rnd28(), 4);

    tag = "R3";
    send_word(28'h0000040, 4);
    send_word(28'h8000000, 4);
    send_word(28'h0000001, 4);
    send_word(28'h1000000, 4);
    send_word(28'h5555555, 4);
    repeat (12) send_word(rnd28(), 4);

    tag = "R7";
    send_word(rnd28(), 0);
    repeat (4) send_word(rnd28(), 4);

    tag = "R8";
    repeat (5) send_word(rnd28(), 0);
    tag = "R4";
    repeat (7) send_word(rnd28(), 4);

    // power-down with a live link on the lanes
    tag = "R9";
    @(negedge clk);
    pwr_ni = 1'b0;
    for (int i = 0; i < 14; i++) begin
      ck_lane = ((i % 7) < 4);
      dl = 4'($urandom());
      @(negedge clk);
      chk(out_word() == '0 && !lock_o && !pix_clk_o, "R9 cleared", out_word(), '0);
    end
    pwr_ni = 1'b1;
    ck_lane = 1'b0;
    dl = '0;
    reset_model();

    tag = "R10";
    repeat (8) send_word(rnd28(), 4);
    repeat (10) send_word(rnd28(), 4);
    send_word(rnd28(), 4);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule